// File: doc/BRIEF.md
# Pointer-Windowed RAM Slave

This block is a memory slave for a synchronous strobe/acknowledge register bus. It holds a RAM of `2**AW` words of 32 bits but occupies only two bus locations. One location is a pointer that selects a word. The other is a data window that reads or writes the selected word. After each access through the window the pointer moves on by one, so a master can stream a whole block through a single bus address. The master sets the start position by writing the pointer.

The RAM read port is registered. A window read therefore takes one wait state. Window writes and pointer accesses complete in the cycle the strobe is first seen.

A read-modify-write is a window read followed at once by a window write. Both halves must touch the same word. For this reason the step that follows a window read is held back for one cycle. If the very next cycle is a window write, that write lands on the word just read and then the pointer steps once. In every other case the held-back step happens anyway.

Top module: `ported_ram_slave`

## Requirements
- R1: After reset the pointer reads as 0 and `busAck` is low while `busStb` is low.
- R2: Only `busAddr[0]` is decoded: 0 selects the pointer and 1 selects the data window. All higher address bits have no effect.
- R3: A pointer write loads `busWdata[AW-1:0]` and is acknowledged in the same cycle. A pointer read returns the current pointer, zero-extended, in the same cycle.
- R4: A window write stores `busWdata` into the word the pointer selects. It is acknowledged in the same cycle and advances the pointer by one.
- R5: A window read is acknowledged in the second cycle of its strobe (one wait state). It returns the selected word and advances the pointer by one.
- R6: The pointer is AW bits wide. It steps from `2**AW-1` to 0. A pointer write keeps only the low AW bits of the data.
- R7: A window write that begins in the cycle right after a window read's acknowledge writes the word that was just read. Across the two accesses the pointer advances by exactly one.
- R8: `busAck` is high only while `busStb` is high. It drops in the same cycle the strobe falls, including during a read wait state. Cycles may follow back to back with the strobe held high.
- R9: A pointer write in the cycle right after a window read's acknowledge takes precedence over the held-back step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | ADDR_W | Bus address; only bit 0 is decoded |
| busWdata | input | DATA_W | Write data |
| busWe | input | 1 | 1 for write, 0 for read |
| busStb | input | 1 | Strobe; qualifies a cycle |
| busRdata | output | DATA_W | Read data, valid with `busAck` |
| busAck | output | 1 | Acknowledge; ends the cycle |

## Verification
The one case where two functions land in the same cycle is the cycle right after a window read's acknowledge. In that cycle the held-back pointer step meets the next access, which may be a window write (read-modify-write), a pointer write, a pointer read or another window read. The bench provokes each of these by issuing the second access with the strobe still high, straight after the read. It then judges the result arithmetically from the pointer read-back and from the RAM contents read at computed positions. A separate case puts an idle cycle between the read and the write, and checks that the write then lands on the next word.

// File: rtl/pram_pkg.sv
package pram_pkg;
  typedef struct packed {
    logic ptrLoad;
    logic ptrStep;
    logic ramWr;
    logic ramRd;
    logic useNext;
    logic selRam;
  } ctlStrobes_t;
endpackage

// File: rtl/pram_ctrl.sv
module pram_ctrl
  import pram_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        busAddr0,
  input  logic        busWe,
  input  logic        busStb,
  output ctlStrobes_t ctl,
  output logic        busAck
);
  logic rdPhase;
  logic pend;
  logic ptrAcc, dWr, dRdStart, dRdDone;

  always_comb begin
    ptrAcc   = busStb & ~busAddr0;
    dWr      = busStb & busAddr0 & busWe;
    dRdStart = busStb & busAddr0 & ~busWe & ~rdPhase;
    dRdDone  = busStb & busAddr0 & ~busWe & rdPhase;
    busAck   = ptrAcc | dWr | dRdDone;

    ctl.ptrLoad = ptrAcc & busWe;
    ctl.ptrStep = ~(ptrAcc & busWe) & (pend | dWr);
    ctl.ramWr   = dWr;
    ctl.ramRd   = dRdStart;
    ctl.useNext = pend & ~dWr;
    ctl.selRam  = rdPhase;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPhase <= 1'b0;
      pend    <= 1'b0;
    end else begin
      rdPhase <= dRdStart;
      pend    <= dRdDone;
    end
  end

  // R5: a window read ack is preceded by an unacknowledged read cycle
  assert_read_wait_R5: assert property (@(posedge clk) disable iff (rst)
    (busAck && busAddr0 && !busWe) |-> $past(busStb && busAddr0 && !busWe && !busAck));

  // R8: ack drops with strobe
  assert_ack_drop_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busStb) |-> !busAck);

  // R7: the held-back step lasts exactly one cycle
  assert_pend_single_R7: assert property (@(posedge clk) disable iff (rst)
    pend |=> !pend);
endmodule

// File: rtl/pram_datapath.sv
module pram_datapath
  import pram_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       ctl,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata
);
  localparam int DEPTH = 2 ** AW;

  logic [AW-1:0]     ptr;
  logic [AW-1:0]     ptrInc;
  logic [AW-1:0]     addrSel;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ramQ;

  always_comb begin
    ptrInc   = ptr + 1'b1;
    addrSel  = ctl.useNext ? ptrInc : ptr;
    busRdata = ctl.selRam ? ramQ : {{(DATA_W-AW){1'b0}}, addrSel};
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (ctl.ptrLoad) ptr <= busWdata[AW-1:0];
    else if (ctl.ptrStep) ptr <= ptrInc;
  end

  always_ff @(posedge clk) begin
    if (ctl.ramWr) mem[addrSel] <= busWdata;
    if (ctl.ramRd) ramQ <= mem[addrSel];
  end

  // R3: a pointer load takes the low data bits
  assert_ptr_load_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(ctl.ptrLoad) && !$past(rst)) |-> ptr == $past(busWdata[AW-1:0]));

  // R6: stepping from the last word wraps to zero
  assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(ctl.ptrStep) && !$past(ctl.ptrLoad) && !$past(rst) && ($past(ptr) == '1))
      |-> ptr == '0);
endmodule

// File: rtl/ported_ram_slave.sv
module ported_ram_slave
  import pram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  input  logic              busStb,
  output logic [DATA_W-1:0] busRdata,
  output logic              busAck
);
  ctlStrobes_t ctl;

  pram_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .busAddr0 (busAddr[0]),
    .busWe    (busWe),
    .busStb   (busStb),
    .ctl      (ctl),
    .busAck   (busAck)
  );

  pram_datapath #(.DATA_W(DATA_W), .AW(AW)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .busWdata (busWdata),
    .busRdata (busRdata)
  );
endmodule

// File: tb/ported_ram_slave_bench.sv
module ported_ram_slave_bench;
  localparam int AW = 4;
  localparam int DEPTH = 2 ** AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic        busStb = 1'b0;
  logic [31:0] busRdata;
  logic        busAck;

  int total = 0;
  int fails = 0;
  logic [31:0] model [DEPTH];
  logic [31:0] rd;
  int waits;

  always #5 clk = ~clk;

  ported_ram_slave #(.ADDR_W(32), .DATA_W(32), .AW(AW)) u_ported_ram_slave (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busStb(busStb), .busRdata(busRdata), .busAck(busAck)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doCycle(input logic [31:0] a, input logic we, input logic [31:0] wd,
                         output logic [31:0] rdo, output int w);
    busAddr = a; busWe = we; busWdata = wd; busStb = 1'b1; w = 0;
    #1;
    while (!busAck && w < 8) begin
      @(negedge clk); #1; w++;
    end
    rdo = busRdata;
    @(negedge clk);
  endtask

  task automatic idle();
    busStb = 1'b0; busWe = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] pat(input int i, input int k);
    return 32'h3C00_0000 + i * 32'h0001_0203 + k * 32'h0100_0000 ^ 32'h5A;
  endfunction

  initial begin
    #2_000_000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(busAck == 1'b0, "R1 ack idle", {31'b0, busAck}, 0);
    @(negedge clk);
    doCycle(32'h0, 0, 0, rd, waits);
    chk(rd == 0, "R1 pointer after reset", rd, 0);
    idle();

    // R4: fill all words back to back, starting from the reset pointer (0)
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = pat(i, 1);
      doCycle(32'h1, 1, model[i], rd, waits);
      chk(waits == 0, "R4 write zero wait", waits, 0);
    end
    doCycle(32'h0, 0, 0, rd, waits);
    chk(rd == 0, "R6 pointer wrapped after full write", rd, 0);

    // R5: read all back, back to back
    for (int i = 0; i < DEPTH; i++) begin
      doCycle(32'h1, 0, 0, rd, waits);
      chk(rd == model[i], "R5 read data", rd, model[i]);
      chk(waits == 1, "R5 one wait state", waits, 1);
    end
    idle();
    doCycle(32'h0, 0, 0, rd, waits);
    chk(rd == 0 && waits == 0, "R6 R3 pointer wrapped after full read", rd, 0);
    idle();

    // R3/R2: every start position, with upper address bits set
    for (int s = 0; s < DEPTH; s++) begin
      doCycle(32'hFFFF_FFF0, 1, s, rd, waits);
      chk(waits == 0, "R3 pointer write zero wait", waits, 0);
      doCycle(32'hABCD_0000, 0, 0, rd, waits);
      chk(rd == s, "R3 R2 pointer readback", rd, s);
      doCycle(32'h8000_0001, 0, 0, rd, waits);
      chk(rd == model[s], "R2 R5 data at start", rd, model[s]);
      doCycle(32'h0, 0, 0, rd, waits);
      chk(rd == ((s + 1) % DEPTH), "R5 pointer step after read", rd, (s + 1) % DEPTH);
      idle();
    end

    // R6: pointer write keeps low bits
    doCycle(32'h0, 1, 32'h0000_0123, rd, waits);
    doCycle(32'h0, 0, 0, rd, waits);
    chk(rd == 32'h3, "R6 pointer low bits", rd, 3);
    idle();

    // R7: read-modify-write at 5 and at the last word
    foreach (model[j]) begin
      if (j == 5 || j == DEPTH - 1) begin
        doCycle(32'h0, 1, j, rd, waits);
        doCycle(32'h1, 0, 0, rd, waits);
        chk(rd == model[j], "R7 rmw read half", rd, model[j]);
        model[j] = rd ^ 32'hFFFF_0000;
        doCycle(32'h1, 1, model[j], rd, waits);
        doCycle(32'h0, 0, 0, rd, waits);
        chk(rd == ((j + 1) % DEPTH), "R7 rmw single step", rd, (j + 1) % DEPTH);
        doCycle(32'h0, 1, j, rd, waits);
        doCycle(32'h1, 0, 0, rd, waits);
        chk(rd == model[j], "R7 rmw same word", rd, model[j]);
        idle();
      end
    end

    // R7: read, idle, write lands on next word
    doCycle(32'h0, 1, 7, rd, waits);
    doCycle(32'h1, 0, 0, rd, waits);
    idle();
    model[8] = 32'hDEAD_0008;
    doCycle(32'h1, 1, model[8], rd, waits);
    doCycle(32'h0, 0, 0, rd, waits);
    chk(rd == 9, "R7 separated write steps twice", rd, 9);
    doCycle(32'h0, 1, 7, rd, waits);
    doCycle(32'h1, 0, 0, rd, waits);
    chk(rd == model[7], "R7 word 7 untouched", rd, model[7]);
    doCycle(32'h1, 0, 0, rd, waits);
    chk(rd == model[8], "R7 word 8 written", rd, model[8]);
    idle();

    // R9: pointer write right after a read ack wins
    doCycle(32'h0, 1, 3, rd, waits);
    doCycle(32'h1, 0, 0, rd, waits);
    doCycle(32'h0, 1, 9, rd, waits);
    doCycle(32'h0, 0, 0, rd, waits);
    chk(rd == 9, "R9 pointer write precedence", rd, 9);
    idle();

    // R8: strobe dropped during the read wait state
    busAddr = 32'h1; busWe = 1'b0; busStb = 1'b1;
    #1;
    chk(busAck == 1'b0, "R8 no ack in wait state", {31'b0, busAck}, 0);
    @(negedge clk);
    busStb = 1'b0;
    #1;
    chk(busAck == 1'b0, "R8 ack low after strobe drop", {31'b0, busAck}, 0);
    @(negedge clk);
    busAddr = 32'h0; busStb = 1'b1;
    #1;
    chk(busAck == 1'b1, "R8 ack with pointer strobe", {31'b0, busAck}, 1);
    chk(busRdata == 9, "R8 abandoned read did not step", busRdata, 9);
    @(negedge clk);
    busStb = 1'b0;
    #1;
    chk(busAck == 1'b0, "R8 ack falls with strobe", {31'b0, busAck}, 0);
    @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule